// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block sits behind a management-bus serial front end and turns parsed 16-bit MDIO frames into accesses on a 32-bit internal register bus, or hands them on to the internal PHYs. Each frame carries a 5-bit PHY address, a 5-bit register number, a direction and, for writes, 16 data bits. The two top bits of the PHY address choose what the frame means. The three lower bits and the register number then act as low address bits or as the PHY target.

A 10-bit page register supplies the upper byte-address bits. Each page opens a 512-byte window of 32-bit registers on a 4-byte stride. A 32-bit register is reached as two 16-bit halves. A write to the upper half is only held in the bridge. The write to the lower half then sends the whole word in one internal write, so trigger bits in the lower half act on a complete value. A read of the lower half fetches the whole register and keeps its upper half. A following read of the upper half returns that kept copy, so both halves come from the same fetch.

The front end presents one frame at a time as a one-cycle `frmValid` pulse. It then waits for the one-cycle `frmDone` pulse, which carries `frmRdata`.

Top module: `mdioBridge`

## Requirements
- R1: PHY address bits 4:3 select the frame kind: 3 is page select, 2 is register access, 0 is PHY pass-through. The value 1 is ignored: no internal or PHY access takes place, and the frame completes with read data 0.
- R2: A page-select write loads data bits 9:0 into the page register, which drives internal byte-address bits 18:9. A page-select read returns 0 and leaves the page unchanged.
- R3: In register mode the internal byte address is formed from the page (bits 18:9), PHY address bits 2:0 (bits 8:6) and register number bits 4:1 (bits 5:2). Bits 1:0 are always 0.
- R4: A register-mode write with register number bit 0 = 1 (upper half) only stores the data in a staging register. It makes no internal access and completes one cycle after acceptance. A later upper-half write replaces the staged value.
- R5: A register-mode write with register number bit 0 = 0 (lower half) issues exactly one internal write. Its data is the staged upper half in bits 31:16 and the frame data in bits 15:0.
- R6: A register-mode read of the lower half issues one internal read and returns bits 15:0. It also keeps bits 31:16. A read of the upper half returns the kept value without any internal access.
- R7: In pass-through mode the bridge forwards the direction, PHY address bits 2:0, the register number and the data to the PHY port. It holds the request until `phyReady`, and a read returns `phyRdata`. A write returns 0.
- R8: An internal or PHY request stays asserted, with a stable address, until its ready input is high. `frmDone` is a single-cycle pulse in the cycle after that handshake, or in the cycle after acceptance for a frame handled locally. At most one of `regValid` and `phyValid` is high.
- R9: Reset clears the page register, the staged upper half and the kept read half to 0, and deasserts `frmDone`, `regValid` and `phyValid`. `frmRdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | One-cycle pulse: parsed frame present |
| frmWrite | input | 1 | 1 = write frame, 0 = read frame |
| frmPhyAddr | input | 5 | Frame PHY address field (kind in bits 4:3) |
| frmRegAddr | input | 5 | Frame register number field |
| frmWdata | input | 16 | Frame write data |
| frmDone | output | 1 | One-cycle pulse: frame complete |
| frmRdata | output | 16 | Read data returned with frmDone |
| regValid | output | 1 | Internal register request |
| regWrite | output | 1 | Internal request is a write |
| regAddr | output | 19 | Internal byte address |
| regWdata | output | 32 | Internal write data |
| regReady | input | 1 | Internal request accepted this cycle |
| regRdata | input | 32 | Internal read data, valid with regReady |
| phyValid | output | 1 | PHY pass-through request |
| phyWrite | output | 1 | PHY request is a write |
| phyAddr | output | 3 | Internal PHY select |
| phyReg | output | 5 | PHY register number |
| phyWdata | output | 16 | PHY write data |
| phyReady | input | 1 | PHY request accepted this cycle |
| phyRdata | input | 16 | PHY read data, valid with phyReady |

## Verification
Locally handled frames (page select, upper-half write, upper-half read, ignored kind) raise `frmDone` in the cycle right after the acceptance edge. Forwarded frames raise it one cycle after the handshake, which is 1 + N cycles after acceptance when ready comes N cycles late. The bench counts falling edges from acceptance until `frmDone` and compares that count with the expected latency for every frame, under internal and PHY ready delays of 0, 2 and 3. Data, address and access counts are sampled on the same falling edge, after the handshake edge has updated the bench's bus monitor.

// File: rtl/mdioBridgePkg.sv
package mdioBridgePkg;

  // frame kind carried in PHY address bits 4:3
  typedef enum logic [1:0] {
    KIND_PHY  = 2'd0,
    KIND_RSVD = 2'd1,
    KIND_REG  = 2'd2,
    KIND_PAGE = 2'd3
  } frameKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch frame fields
    logic loadPage;   // page <= frame data
    logic stageHigh;  // staged upper half <= frame data
    logic outHigh;    // return kept upper half
    logic outZero;    // return zero
    logic regTake;    // internal handshake done
    logic phyTake;    // PHY handshake done
  } bridgeStrobeT;

endpackage

// File: rtl/mdioBridgeCtrl.sv
module mdioBridgeCtrl
  import mdioBridgePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frmValid,
  input  logic         frmWrite,
  input  logic [1:0]   frmKindBits,
  input  logic         frmUpperHalf,
  input  logic         regReady,
  input  logic         phyReady,
  output bridgeStrobeT strb,
  output logic         regValid,
  output logic         phyValid,
  output logic         frmDone,
  output logic         busy
);

  typedef enum logic [1:0] {S_IDLE, S_REG, S_PHY, S_DONE} stateT;

  stateT     state, stateNext;
  frameKindT kind;

  assign kind = frameKindT'(frmKindBits);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (frmValid) begin
          strb.capture = 1'b1;
          unique case (kind)
            KIND_PAGE: begin
              strb.loadPage = frmWrite;
              strb.outZero  = 1'b1;
              stateNext     = S_DONE;
            end
            KIND_REG: begin
              if (frmUpperHalf && frmWrite) begin
                strb.stageHigh = 1'b1;
                strb.outZero   = 1'b1;
                stateNext      = S_DONE;
              end else if (frmUpperHalf) begin
                strb.outHigh = 1'b1;
                stateNext    = S_DONE;
              end else begin
                stateNext = S_REG;
              end
            end
            KIND_PHY: stateNext = S_PHY;
            default: begin
              strb.outZero = 1'b1;
              stateNext    = S_DONE;
            end
          endcase
        end
      end
      S_REG: begin
        if (regReady) begin
          strb.regTake = 1'b1;
          stateNext    = S_DONE;
        end
      end
      S_PHY: begin
        if (phyReady) begin
          strb.phyTake = 1'b1;
          stateNext    = S_DONE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign regValid = (state == S_REG);
  assign phyValid = (state == S_PHY);
  assign frmDone  = (state == S_DONE);
  assign busy     = (state != S_IDLE);

endmodule

// File: rtl/mdioBridgeData.sv
module mdioBridgeData
  import mdioBridgePkg::*;
#(
  parameter int PAGE_BITS = 10,
  parameter int HALF_W    = 16,
  parameter int LOCAL_W   = 3,
  parameter int REG_W     = 5,
  localparam int WORD_W   = 2 * HALF_W,
  localparam int ADDR_W   = PAGE_BITS + LOCAL_W + REG_W + 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  bridgeStrobeT       strb,
  input  logic               frmWrite,
  input  logic [LOCAL_W-1:0] frmLocal,
  input  logic [REG_W-1:0]   frmRegAddr,
  input  logic [HALF_W-1:0]  frmWdata,
  input  logic [WORD_W-1:0]  regRdata,
  input  logic [HALF_W-1:0]  phyRdata,
  output logic [HALF_W-1:0]  frmRdata,
  output logic               regWrite,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [WORD_W-1:0]  regWdata,
  output logic               phyWrite,
  output logic [LOCAL_W-1:0] phyAddr,
  output logic [REG_W-1:0]   phyReg,
  output logic [HALF_W-1:0]  phyWdata
);

  logic                 latWrite;
  logic [LOCAL_W-1:0]   latLocal;
  logic [REG_W-1:0]     latReg;
  logic [HALF_W-1:0]    latData;
  logic [PAGE_BITS-1:0] pageSel;
  logic [HALF_W-1:0]    stagedHigh;
  logic [HALF_W-1:0]    keptHigh;
  logic [HALF_W-1:0]    outData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latWrite <= 1'b0;
      latLocal <= '0;
      latReg   <= '0;
      latData  <= '0;
    end else if (strb.capture) begin
      latWrite <= frmWrite;
      latLocal <= frmLocal;
      latReg   <= frmRegAddr;
      latData  <= frmWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pageSel <= '0;
    else if (strb.loadPage) pageSel <= frmWdata[PAGE_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stagedHigh <= '0;
    else if (strb.stageHigh) stagedHigh <= frmWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keptHigh <= '0;
      outData  <= '0;
    end else begin
      if (strb.outZero) outData <= '0;
      if (strb.outHigh) outData <= keptHigh;
      if (strb.regTake) begin
        if (latWrite) begin
          outData <= '0;
        end else begin
          outData  <= regRdata[HALF_W-1:0];
          keptHigh <= regRdata[WORD_W-1:HALF_W];
        end
      end
      if (strb.phyTake) outData <= latWrite ? '0 : phyRdata;
    end
  end

  // word address: half select dropped, byte bits 1:0 forced to zero
  assign regAddr  = {pageSel, latLocal, latReg[REG_W-1:1], 2'b00};
  assign regWrite = latWrite;
  assign regWdata = {stagedHigh, latData};
  assign phyWrite = latWrite;
  assign phyAddr  = latLocal;
  assign phyReg   = latReg;
  assign phyWdata = latData;
  assign frmRdata = outData;

endmodule

// File: rtl/mdioBridge.sv
module mdioBridge
  import mdioBridgePkg::*;
#(
  parameter int PAGE_BITS = 10,
  parameter int HALF_W    = 16,
  localparam int LOCAL_W  = 3,
  localparam int REG_W    = 5,
  localparam int WORD_W   = 2 * HALF_W,
  localparam int ADDR_W   = PAGE_BITS + LOCAL_W + REG_W + 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               frmValid,
  input  logic               frmWrite,
  input  logic [4:0]         frmPhyAddr,
  input  logic [REG_W-1:0]   frmRegAddr,
  input  logic [HALF_W-1:0]  frmWdata,
  output logic               frmDone,
  output logic [HALF_W-1:0]  frmRdata,
  output logic               regValid,
  output logic               regWrite,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [WORD_W-1:0]  regWdata,
  input  logic               regReady,
  input  logic [WORD_W-1:0]  regRdata,
  output logic               phyValid,
  output logic               phyWrite,
  output logic [LOCAL_W-1:0] phyAddr,
  output logic [REG_W-1:0]   phyReg,
  output logic [HALF_W-1:0]  phyWdata,
  input  logic               phyReady,
  input  logic [HALF_W-1:0]  phyRdata
);

  bridgeStrobeT strb;
  logic         busy;

  mdioBridgeCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frmValid     (frmValid),
    .frmWrite     (frmWrite),
    .frmKindBits  (frmPhyAddr[4:3]),
    .frmUpperHalf (frmRegAddr[0]),
    .regReady     (regReady),
    .phyReady     (phyReady),
    .strb         (strb),
    .regValid     (regValid),
    .phyValid     (phyValid),
    .frmDone      (frmDone),
    .busy         (busy)
  );

  mdioBridgeData #(
    .PAGE_BITS (PAGE_BITS),
    .HALF_W    (HALF_W),
    .LOCAL_W   (LOCAL_W),
    .REG_W     (REG_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .frmWrite   (frmWrite),
    .frmLocal   (frmPhyAddr[LOCAL_W-1:0]),
    .frmRegAddr (frmRegAddr),
    .frmWdata   (frmWdata),
    .regRdata   (regRdata),
    .phyRdata   (phyRdata),
    .frmRdata   (frmRdata),
    .regWrite   (regWrite),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .phyWrite   (phyWrite),
    .phyAddr    (phyAddr),
    .phyReg     (phyReg),
    .phyWdata   (phyWdata)
  );

endmodule

// File: rtl/mdioBridgeChk.sv
module mdioBridgeChk #(
  parameter int ADDR_W = 19,
  parameter int WORD_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              frmValid,
  input logic              frmWrite,
  input logic [4:0]        frmPhyAddr,
  input logic [4:0]        frmRegAddr,
  input logic              frmDone,
  input logic              regValid,
  input logic              regReady,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0] regWdata,
  input logic              phyValid,
  input logic              phyReady,
  input logic [2:0]        phyAddr
);

  a_r8_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && phyValid));

  a_r8_reg_hold: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regReady |=> regValid && $stable(regAddr) && $stable(regWdata));

  a_r8_done_after_reg: assert property (@(posedge clk) disable iff (!rstN)
    regValid && regReady |=> frmDone);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frmDone |=> !frmDone);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> regAddr[1:0] == 2'b00);

  a_r4_upper_write_local: assert property (@(posedge clk) disable iff (!rstN)
    !busy && frmValid && frmWrite && frmPhyAddr[4:3] == 2'b10 && frmRegAddr[0]
    |=> frmDone && !regValid);

  a_r1_rsvd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !busy && frmValid && frmPhyAddr[4:3] == 2'b01
    |=> frmDone && !regValid && !phyValid);

  a_r7_phy_hold: assert property (@(posedge clk) disable iff (!rstN)
    phyValid && !phyReady |=> phyValid && $stable(phyAddr));

endmodule

bind mdioBridge mdioBridgeChk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .frmValid   (frmValid),
  .frmWrite   (frmWrite),
  .frmPhyAddr (frmPhyAddr),
  .frmRegAddr (frmRegAddr),
  .frmDone    (frmDone),
  .regValid   (regValid),
  .regReady   (regReady),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .phyValid   (phyValid),
  .phyReady   (phyReady),
  .phyAddr    (phyAddr)
);

// File: tb/sim_mdioBridge.sv
`timescale 1ns/1ps
module sim_mdioBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic        frmWrite = 1'b0;
  logic [4:0]  frmPhyAddr = '0;
  logic [4:0]  frmRegAddr = '0;
  logic [15:0] frmWdata = '0;
  logic        frmDone;
  logic [15:0] frmRdata;
  logic        regValid, regWrite, regReady;
  logic [18:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic        phyValid, phyWrite, phyReady;
  logic [2:0]  phyAddr;
  logic [4:0]  phyReg;
  logic [15:0] phyWdata, phyRdata;

  always #2.5 clk = ~clk;

  mdioBridge u0 (.*);

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  // bus models with programmable ready delay
  int regLat = 0, phyLat = 0, regWait = 0, phyWait = 0;
  int wrCnt = 0, rdCnt = 0, phyCnt = 0;
  logic [18:0] lastAddr = '0;
  logic [31:0] lastWd = '0;
  logic [2:0]  lastPhyAddr = '0;
  logic [4:0]  lastPhyReg = '0;
  logic [15:0] lastPhyWd = '0;
  logic        lastPhyWr = 1'b0;

  assign regReady = regValid && (regWait >= regLat);
  assign phyReady = phyValid && (phyWait >= phyLat);
  assign regRdata = {regAddr[15:0] ^ 16'hA5A5, regAddr[15:0] ^ 16'h0F0F};
  assign phyRdata = {8'hC0, phyAddr, phyReg};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    regWait <= (regValid && !regReady) ? regWait + 1 : 0;
    phyWait <= (phyValid && !phyReady) ? phyWait + 1 : 0;
    if (regValid && regReady) begin
      if (regWrite) begin wrCnt <= wrCnt + 1; lastWd <= regWdata; end
      else rdCnt <= rdCnt + 1;
      lastAddr <= regAddr;
    end
    if (phyValid && phyReady) begin
      phyCnt <= phyCnt + 1;
      lastPhyAddr <= phyAddr; lastPhyReg <= phyReg;
      lastPhyWd <= phyWdata; lastPhyWr <= phyWrite;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt + 1, failCnt);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doFrame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    frmValid = 1'b1; frmWrite = wr; frmPhyAddr = pa; frmRegAddr = ra; frmWdata = wd;
    @(negedge clk);
    frmValid = 1'b0;
    lat = 0;
    while (!frmDone && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    rd = frmRdata;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wd;
    logic [15:0] expRd;
    logic        expW;
    logic        expR;
    logic [18:0] expAddr;
    logic [31:0] expWd;
    logic [7:0]  lat;
  } vecT;

  localparam vecT VEC [9] = '{
    '{1'b1, 5'h18, 5'h00, 16'h0123, 16'h0000, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R2 page 0x123
    '{1'b1, 5'h15, 5'h07, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R4 stage upper
    '{1'b1, 5'h15, 5'h06, 16'h1234, 16'h0000, 1'b1, 1'b0, 19'h2474C, 32'hBEEF1234, 8'd1}, // R5 R3 commit
    '{1'b0, 5'h12, 5'h1E, 16'h0000, 16'h49B3, 1'b0, 1'b1, 19'h246BC, 32'h0,        8'd1}, // R6 lower read
    '{1'b0, 5'h12, 5'h1F, 16'h0000, 16'hE319, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R6 upper kept
    '{1'b0, 5'h18, 5'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R2 page read 0
    '{1'b1, 5'h08, 5'h02, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R1 kind 1 ignored
    '{1'b1, 5'h18, 5'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 19'h0,     32'h0,        8'd0}, // R2 top page
    '{1'b0, 5'h17, 5'h00, 16'h0000, 16'hF0CF, 1'b0, 1'b1, 19'h7FFC0, 32'h0,        8'd1}  // R3 max address
  };

  initial begin
    logic [15:0] rd;
    int lat, w0, r0, p0;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 frmDone in reset", {63'b0, frmDone}, 64'd0);
    chk("R9 regValid/phyValid in reset", {62'b0, regValid, phyValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 frmRdata after reset", {48'b0, frmRdata}, 64'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      w0 = wrCnt; r0 = rdCnt; p0 = phyCnt;
      doFrame(VEC[i].wr, VEC[i].pa, VEC[i].ra, VEC[i].wd, rd, lat);
      chk($sformatf("R1/vec%0d rdata", i), {48'b0, rd}, {48'b0, VEC[i].expRd});
      chk($sformatf("R8 vec%0d latency", i), 64'(lat), 64'(VEC[i].lat));
      chk($sformatf("R5 vec%0d write count", i), 64'(wrCnt - w0), {63'b0, VEC[i].expW});
      chk($sformatf("R6 vec%0d read count", i), 64'(rdCnt - r0), {63'b0, VEC[i].expR});
      chk($sformatf("R1 vec%0d no PHY access", i), 64'(phyCnt - p0), 64'd0);
      if (VEC[i].expW || VEC[i].expR)
        chk($sformatf("R3 vec%0d address", i), {45'b0, lastAddr}, {45'b0, VEC[i].expAddr});
      if (VEC[i].expW)
        chk($sformatf("R5 vec%0d data", i), {32'b0, lastWd}, {32'b0, VEC[i].expWd});
    end

    // R7: pass-through write with delayed ready
    phyLat = 2; w0 = wrCnt; r0 = rdCnt;
    doFrame(1'b1, 5'h03, 5'd9, 16'h5555, rd, lat);
    chk("R7 phy write fields", {31'b0, lastPhyWr, lastPhyAddr, lastPhyReg, 8'b0, lastPhyWd},
        {31'b0, 1'b1, 3'd3, 5'd9, 8'b0, 16'h5555});
    chk("R8 phy latency", 64'(lat), 64'd3);
    chk("R7 phy write rdata", {48'b0, rd}, 64'd0);
    doFrame(1'b0, 5'h04, 5'd2, 16'h0000, rd, lat);
    chk("R7 phy read rdata", {48'b0, rd}, 64'hC082);
    chk("R7 no internal access", 64'((wrCnt - w0) + (rdCnt - r0)), 64'd0);
    phyLat = 0;

    // R8: internal ready delayed by 3, then R6 consistent upper half
    regLat = 3;
    doFrame(1'b0, 5'h10, 5'h04, 16'h0000, rd, lat); // addr 0x7FE08
    chk("R8 reg latency with wait", 64'(lat), 64'd4);
    chk("R6 lower read data", {48'b0, rd}, {48'b0, 16'hFE08 ^ 16'h0F0F});
    doFrame(1'b0, 5'h10, 5'h05, 16'h0000, rd, lat);
    chk("R6 upper read data", {48'b0, rd}, {48'b0, 16'hFE08 ^ 16'hA5A5});
    chk("R6 upper read latency", 64'(lat), 64'd0);
    regLat = 0;

    // R4: two upper writes, last one wins, nothing issued
    w0 = wrCnt;
    doFrame(1'b1, 5'h10, 5'h01, 16'h1111, rd, lat);
    doFrame(1'b1, 5'h10, 5'h01, 16'h2222, rd, lat);
    chk("R4 no write from upper halves", 64'(wrCnt - w0), 64'd0);
    doFrame(1'b1, 5'h10, 5'h00, 16'h3333, rd, lat);
    chk("R4 last staged upper used", {32'b0, lastWd}, 64'h22223333);

    // R9: reset mid-run clears page, staging and kept half
    doFrame(1'b1, 5'h10, 5'h01, 16'h7777, rd, lat);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    doFrame(1'b0, 5'h10, 5'h01, 16'h0000, rd, lat);
    chk("R9 kept half cleared", {48'b0, rd}, 64'd0);
    doFrame(1'b1, 5'h10, 5'h00, 16'h00AA, rd, lat);
    chk("R9 page cleared", {45'b0, lastAddr}, 64'd0);
    chk("R9 staging cleared", {32'b0, lastWd}, 64'h000000AA);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule